// File: doc/BRIEF.md
# AXI4-Lite Configuration Register Bank

This block is a bank of configuration words behind an AXI4-Lite slave port. Software reads and writes the words over the bus, and the surrounding application logic can also update any word through a one-cycle side write port. Each word is chosen by an index that is the low bits of the bus address. The address is a word index, not a byte address.

Each direction is handled by its own small state machine, and each allows only one transaction in flight. The read machine walks RD_IDLE -> RD_LOAD (on address accept) -> RD_RESP (always, after one processing cycle) -> RD_DONE (on the R handshake) -> RD_IDLE (always). The word is copied into a holding register during RD_LOAD, so the returned data does not move while the master stalls the response.

The write machine walks WR_IDLE -> WR_HAVE_ADDR (address accepted alone) or WR_HAVE_DATA (data accepted alone) or WR_COMMIT (both accepted together). WR_HAVE_ADDR goes to WR_COMMIT when the data arrives, and WR_HAVE_DATA goes to WR_COMMIT when the address arrives. From WR_COMMIT the machine moves to WR_RESP (always), then to WR_DONE (on the B handshake), then back to WR_IDLE (always). The reset is asynchronous and active-low.

Top module: `cfg_regbank_axil`

## Requirements
- R1: While aresetn is low, s_bvalid and s_rvalid are 0 at once, even in the middle of a stalled response. s_arready, s_awready and s_wready are 1 during reset.
- R2: Only one transaction is in flight per channel. s_arready is 0 from the edge that accepts a read address until the edge after the R handshake. s_awready and s_wready are each 0 from their own accept edge until the edge after the B handshake.
- R3: Take a read address accepted at edge k. s_rvalid is 0 after edge k+1 and is 1 from edge k+2. After an R handshake at edge m, s_arready is 0 after m and is 1 again after m+1. Back-to-back reads therefore complete one every four cycles.
- R4: A read returns the word whose index is s_araddr as it was captured. s_rresp is always 0 (OKAY).
- R5: s_rdata holds the word as it stood in the processing cycle. It stays constant while s_rvalid is 1 and s_rready is 0, even if that word is written by the bus or by the side port in the meantime.
- R6: The write response waits for both the address and the data phase, in either order or together. s_bvalid rises at the second edge after the later of the two accepts. s_bresp is always 0 (OKAY).
- R7: A bus write updates the word at index s_awaddr. Bit i of s_wstrb enables byte i (data bits 8i+7..8i), and bytes whose strobe is 0 keep their old value.
- R8: When app_wr_en is 1 at an edge, the whole word at index app_wr_idx takes the value app_wr_data.
- R9: If a bus commit and a side write hit the same index at the same edge, the bytes enabled by the bus take the bus data and the remaining bytes take the side data. When the two hit different indices, both writes take effect.
- R10: s_bvalid stays 1 until s_bready is sampled 1, and s_rvalid stays 1 until s_rready is sampled 1.
- R11: Reset clears every word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Asynchronous reset, active low |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | IDX_W | Write word index |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Byte enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | IDX_W | Read word index |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code, always OKAY |
| app_wr_en | input | 1 | Side write enable |
| app_wr_idx | input | IDX_W | Side write index |
| app_wr_data | input | DATA_W | Side write data |

## Verification
The properties assume that the master keeps each VALID raised until its handshake. They also assume that RREADY and BREADY are the only means of stalling a response. The bench drives every valid from a negative edge and holds it until the matching ready was seen high before a rising edge. It changes the ready signals only at negative edges and asserts reset only between edges, so every property sees a legal bus. Side writes are issued for exactly one cycle, either in isolation or lined up with the edge on which a bus write commits.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_LOAD,
        RD_RESP,
        RD_DONE
    } rd_state_t;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_HAVE_ADDR,
        WR_HAVE_DATA,
        WR_COMMIT,
        WR_RESP,
        WR_DONE
    } wr_state_t;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/cfg_rd_ctrl.sv
module cfg_rd_ctrl
    import cfg_regbank_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    input  logic [IDX_W-1:0]  araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [IDX_W-1:0]  sel_idx,
    input  logic [DATA_W-1:0] sel_word
);

    rd_state_t         state_q, state_d;
    logic              addr_done, resp_running, resp_done;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (arvalid) state_d = RD_LOAD;
            RD_LOAD: state_d = RD_RESP;
            RD_RESP: if (rready) state_d = RD_DONE;
            RD_DONE: state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    // per-phase flags decoded from the state
    always_comb begin
        addr_done    = (state_q != RD_IDLE);
        resp_running = (state_q == RD_RESP);
        resp_done    = (state_q == RD_DONE);
    end

    assign arready = !addr_done;
    assign rvalid  = resp_running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 idx_q <= '0;
        else if (arvalid && arready) idx_q <= araddr;
    end

    // load only in the processing cycle; frozen while the response waits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        data_q <= '0;
        else if (addr_done && !resp_running && !resp_done) data_q <= sel_word;
    end

    assign sel_idx = idx_q;
    assign rdata   = data_q;

    p_rd_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);

    p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready) |=> (!rvalid && !arready) ##1 rvalid);

    p_rd_reopen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready) |=> (!rvalid && !arready) ##1 arready);

    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

endmodule

// File: rtl/cfg_wr_ctrl.sv
module cfg_wr_ctrl
    import cfg_regbank_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [IDX_W-1:0]  awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic              bvalid,
    input  logic              bready,
    output logic              commit_en,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_data,
    output logic [STRB_W-1:0] commit_strb
);

    wr_state_t         state_q, state_d;
    logic              aw_done, w_done, resp_running;
    logic              aw_hs, w_hs;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;

    assign aw_hs = awvalid && awready;
    assign w_hs  = wvalid && wready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (aw_hs && w_hs) state_d = WR_COMMIT;
                else if (aw_hs)    state_d = WR_HAVE_ADDR;
                else if (w_hs)     state_d = WR_HAVE_DATA;
            end
            WR_HAVE_ADDR: if (w_hs)  state_d = WR_COMMIT;
            WR_HAVE_DATA: if (aw_hs) state_d = WR_COMMIT;
            WR_COMMIT:    state_d = WR_RESP;
            WR_RESP:      if (bready) state_d = WR_DONE;
            WR_DONE:      state_d = WR_IDLE;
            default:      state_d = WR_IDLE;
        endcase
    end

    always_comb begin
        aw_done      = !(state_q == WR_IDLE || state_q == WR_HAVE_DATA);
        w_done       = !(state_q == WR_IDLE || state_q == WR_HAVE_ADDR);
        resp_running = (state_q == WR_RESP);
        commit_en    = (state_q == WR_COMMIT);
    end

    assign awready = !aw_done;
    assign wready  = !w_done;
    assign bvalid  = resp_running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     idx_q <= '0;
        else if (aw_hs) idx_q <= awaddr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            strb_q <= '0;
        end else if (w_hs) begin
            data_q <= wdata;
            strb_q <= wstrb;
        end
    end

    assign commit_idx  = idx_q;
    assign commit_data = data_q;
    assign commit_strb = strb_q;

    p_b_after_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (!awready && !wready));

    p_aw_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && awready) |=> !awready);

    p_w_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && wready) |=> !wready);

    p_b_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    p_b_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> bvalid);

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store #(
    parameter int NUM_REGS = 256,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int STRB_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [STRB_W-1:0] bus_strb,
    input  logic              app_we,
    input  logic [IDX_W-1:0]  app_idx,
    input  logic [DATA_W-1:0] app_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        logic [DATA_W-1:0] word_q, word_d;
        logic              bus_hit, app_hit;

        // side data forms the base, bus-enabled bytes override it
        always_comb begin
            bus_hit = bus_we && (bus_idx == IDX_W'(g));
            app_hit = app_we && (app_idx == IDX_W'(g));
            word_d  = app_hit ? app_data : word_q;
            for (int b = 0; b < STRB_W; b++) begin
                if (bus_hit && bus_strb[b]) word_d[b*8 +: 8] = bus_data[b*8 +: 8];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  word_q <= '0;
            else if (bus_hit || app_hit) word_q <= word_d;
        end

        assign words[g] = word_q;
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/cfg_regbank_axil.sv
module cfg_regbank_axil
    import cfg_regbank_pkg::*;
#(
    parameter int NUM_REGS = 256,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int STRB_W  = DATA_W / 8
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [IDX_W-1:0]  s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [IDX_W-1:0]  s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    input  logic              app_wr_en,
    input  logic [IDX_W-1:0]  app_wr_idx,
    input  logic [DATA_W-1:0] app_wr_data
);

    logic              commit_en;
    logic [IDX_W-1:0]  commit_idx;
    logic [DATA_W-1:0] commit_data;
    logic [STRB_W-1:0] commit_strb;
    logic [IDX_W-1:0]  sel_idx;
    logic [DATA_W-1:0] sel_word;

    cfg_wr_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_wr (
        .clk         (aclk),
        .rst_n       (aresetn),
        .awvalid     (s_awvalid),
        .awready     (s_awready),
        .awaddr      (s_awaddr),
        .wvalid      (s_wvalid),
        .wready      (s_wready),
        .wdata       (s_wdata),
        .wstrb       (s_wstrb),
        .bvalid      (s_bvalid),
        .bready      (s_bready),
        .commit_en   (commit_en),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .commit_strb (commit_strb)
    );

    cfg_rd_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd (
        .clk      (aclk),
        .rst_n    (aresetn),
        .arvalid  (s_arvalid),
        .arready  (s_arready),
        .araddr   (s_araddr),
        .rvalid   (s_rvalid),
        .rready   (s_rready),
        .rdata    (s_rdata),
        .sel_idx  (sel_idx),
        .sel_word (sel_word)
    );

    cfg_reg_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk      (aclk),
        .rst_n    (aresetn),
        .bus_we   (commit_en),
        .bus_idx  (commit_idx),
        .bus_data (commit_data),
        .bus_strb (commit_strb),
        .app_we   (app_wr_en),
        .app_idx  (app_wr_idx),
        .app_data (app_wr_data),
        .rd_idx   (sel_idx),
        .rd_data  (sel_word)
    );

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

    p_reset_quiet_r1: assert property (@(posedge aclk)
        !aresetn |-> (!s_rvalid && !s_bvalid && s_arready && s_awready && s_wready));

    p_r_hold_r10: assert property (@(posedge aclk) disable iff (!aresetn)
        (s_rvalid && !s_rready) |=> s_rvalid);

endmodule

// File: tb/cfg_regbank_axil_bench.sv
`timescale 1ns/1ps
module cfg_regbank_axil_bench;

    localparam int NUM_REGS = 256;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 8;
    localparam int STRB_W   = 4;

    logic              aclk = 1'b0;
    logic              aresetn = 1'b0;
    logic              s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
    logic              s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [IDX_W-1:0]  s_awaddr = '0, s_araddr = '0, app_wr_idx = '0;
    logic [DATA_W-1:0] s_wdata = '0, app_wr_data = '0, s_rdata;
    logic [STRB_W-1:0] s_wstrb = '0;
    logic [1:0]        s_bresp, s_rresp;
    logic              app_wr_en = 0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DATA_W-1:0] model [NUM_REGS];

    always #2.5 aclk = ~aclk;

    cfg_regbank_axil #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_cfg_regbank_axil (
        .aclk, .aresetn,
        .s_awvalid, .s_awready, .s_awaddr,
        .s_wvalid, .s_wready, .s_wdata, .s_wstrb,
        .s_bvalid, .s_bready, .s_bresp,
        .s_arvalid, .s_arready, .s_araddr,
        .s_rvalid, .s_rready, .s_rdata, .s_rresp,
        .app_wr_en, .app_wr_idx, .app_wr_data
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] strb);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (strb[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    // order: 0 together, 1 address first, 2 data first. Returns at the
    // negedge after bvalid rose when s_bready is 0.
    task automatic bus_wr(input int idx, input logic [31:0] d, input logic [3:0] strb,
                          input int order, input bit side_en, input int side_idx,
                          input logic [31:0] side_d);
        s_awaddr = IDX_W'(idx);
        s_wdata  = d;
        s_wstrb  = strb;
        if (order != 2) s_awvalid = 1;
        if (order != 1) s_wvalid  = 1;
        while (s_awvalid || s_wvalid) begin
            bit aw_go, w_go;
            aw_go = s_awvalid && s_awready;
            w_go  = s_wvalid && s_wready;
            @(negedge aclk);
            if (aw_go) begin
                s_awvalid = 0;
                if (order == 2) chk("R2 awready low after accept", 32'(s_awready), 0);
            end
            if (w_go) begin
                s_wvalid = 0;
                if (order == 1) chk("R2 wready low after accept", 32'(s_wready), 0);
            end
            if (aw_go && order == 1 && !w_go) s_wvalid = 1;
            if (w_go && order == 2 && !aw_go) s_awvalid = 1;
        end
        chk("R6 bvalid low in commit cycle", 32'(s_bvalid), 0);
        if (side_en) begin
            app_wr_en = 1; app_wr_idx = IDX_W'(side_idx); app_wr_data = side_d;
            model[side_idx] = side_d;
        end
        model[idx] = merge(model[idx], d, strb);
        @(negedge aclk);
        app_wr_en = 0;
        chk("R6 bvalid two edges after last accept", 32'(s_bvalid), 1);
        chk("R6 bresp okay", 32'(s_bresp), 0);
        if (s_bready) begin
            @(negedge aclk);
            chk("R2 awready low after B handshake", 32'(s_awready), 0);
            chk("R6 bvalid cleared", 32'(s_bvalid), 0);
            @(negedge aclk);
            chk("R2 awready back", 32'(s_awready), 1);
        end
    endtask

    task automatic bus_rd(input int idx, output logic [31:0] d);
        s_araddr  = IDX_W'(idx);
        s_arvalid = 1;
        while (!s_arready) @(negedge aclk);
        @(negedge aclk);
        s_arvalid = 0;
        chk("R3 rvalid low in processing cycle", 32'(s_rvalid), 0);
        chk("R2 arready low after accept", 32'(s_arready), 0);
        @(negedge aclk);
        chk("R3 rvalid two edges after accept", 32'(s_rvalid), 1);
        chk("R4 rresp okay", 32'(s_rresp), 0);
        d = s_rdata;
        if (s_rready) begin
            @(negedge aclk);
            chk("R3 arready low after R handshake", 32'(s_arready), 0);
            @(negedge aclk);
            chk("R3 arready back after four cycles", 32'(s_arready), 1);
        end
    endtask

    initial begin : main
        logic [31:0] v, held;
        for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
        #1;
        chk("R1 rvalid in reset", 32'(s_rvalid), 0);
        chk("R1 bvalid in reset", 32'(s_bvalid), 0);
        chk("R1 readies in reset", {29'd0, s_arready, s_awready, s_wready}, 32'h7);
        repeat (3) @(negedge aclk);
        aresetn = 1;
        @(negedge aclk);

        // R11: zero after reset, sample of indices
        for (int i = 0; i < NUM_REGS; i += 37) begin
            bus_rd(i, v);
            chk("R11 cleared word", v, 0);
        end

        // R7/R6/R4: every index, all three phase orders
        for (int i = 0; i < NUM_REGS; i++)
            bus_wr(i, 32'h9E37_0000 + 32'(i) * 32'h0001_0203, 4'hF, i % 3, 0, 0, 0);
        for (int i = 0; i < NUM_REGS; i++) begin
            bus_rd(i, v);
            chk("R4 read by index", v, model[i]);
        end

        // R7: every strobe pattern on one word
        for (int s = 0; s < 16; s++) begin
            bus_wr(5, 32'h1122_3344 ^ (32'(s) * 32'h0101_0101), 4'(s), s % 3, 0, 0, 0);
            bus_rd(5, v);
            chk("R7 byte strobes", v, model[5]);
        end

        // R8: side writes alone
        for (int i = 0; i < 8; i++) begin
            @(negedge aclk);
            app_wr_en = 1; app_wr_idx = IDX_W'(i * 31); app_wr_data = 32'hC0DE_0000 | 32'(i);
            model[i * 31] = app_wr_data;
            @(negedge aclk);
            app_wr_en = 0;
            bus_rd(i * 31, v);
            chk("R8 side write", v, model[i * 31]);
        end

        // R9: collisions on the commit edge
        bus_wr(20, 32'hAAAA_AAAA, 4'b0101, 0, 1, 20, 32'h5555_5555);
        bus_rd(20, v);
        chk("R9 same index merge", v, 32'h55AA_55AA);
        bus_wr(21, 32'h1234_5678, 4'hF, 1, 1, 22, 32'h8765_4321);
        bus_rd(21, v);
        chk("R9 different index bus", v, 32'h1234_5678);
        bus_rd(22, v);
        chk("R9 different index side", v, 32'h8765_4321);

        // R5/R10: stalled read while the word is rewritten
        s_rready = 0;
        bus_rd(7, held);
        chk("R5 value at processing cycle", held, model[7]);
        @(negedge aclk);
        app_wr_en = 1; app_wr_idx = 7; app_wr_data = 32'hFEED_F00D;
        model[7] = app_wr_data;
        @(negedge aclk);
        app_wr_en = 0;
        bus_wr(7, 32'h0BAD_CAFE, 4'hF, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge aclk);
            chk("R10 rvalid held", 32'(s_rvalid), 1);
            chk("R5 rdata stable while stalled", s_rdata, held);
        end
        s_rready = 1;
        @(negedge aclk);
        chk("R10 rvalid drops after handshake", 32'(s_rvalid), 0);
        @(negedge aclk);
        bus_rd(7, v);
        chk("R5 new value after stall", v, 32'h0BAD_CAFE);

        // R10: stalled write response
        s_bready = 0;
        bus_wr(9, 32'h0000_0099, 4'hF, 2, 0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge aclk);
            chk("R10 bvalid held", 32'(s_bvalid), 1);
        end
        s_bready = 1;
        @(negedge aclk);
        chk("R10 bvalid drops", 32'(s_bvalid), 0);
        @(negedge aclk);

        // R1: reset in the middle of stalled responses
        s_rready = 0; s_bready = 0;
        bus_wr(11, 32'h1111_2222, 4'hF, 0, 0, 0, 0);
        bus_rd(11, v);
        chk("R1 setup both stalled", {30'd0, s_bvalid, s_rvalid}, 32'h3);
        #1 aresetn = 0;
        #0.5;
        chk("R1 rvalid cleared at once", 32'(s_rvalid), 0);
        chk("R1 bvalid cleared at once", 32'(s_bvalid), 0);
        @(negedge aclk);
        chk("R1 readies high in reset", {29'd0, s_arready, s_awready, s_wready}, 32'h7);
        s_rready = 1; s_bready = 1;
        aresetn = 1;
        for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
        @(negedge aclk);
        bus_rd(11, v);
        chk("R11 cleared after second reset", v, 0);
        bus_rd(20, v);
        chk("R11 cleared after second reset", v, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge aclk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule